// File: doc/BRIEF.md
# Oversampled Serial Receiver with Majority Voting

This block receives asynchronous serial frames made of one start bit, eight data bits sent least significant bit first, and one stop bit. It runs off a one-cycle sampling tick that an outside divider asserts sixteen times per bit period. The block finds the falling edge of the start bit to within one tick. It keeps a 4-bit phase count through each bit and decides every bit by a majority vote over a window of ticks that software selects.

Four window sizes are available: one centre tick, three ticks around the centre, the eight middle ticks, or all sixteen. Narrow windows tolerate a larger baud mismatch. Wide windows tolerate more line noise. When the realign option is on, every data transition seen inside a frame resets the phase count, so timing error stops building up from bit to bit. Each completed frame yields the byte, a one-cycle valid strobe and a framing flag.

Top module: `uart_vote_rx`

## Requirements
- R1: After reset `rxValid` is 0, `rxData` is 0 and `frameErr` is 0.
- R2: On an idle line, the first tick that sees the line low becomes phase 0 of the start bit. If the line is high again at phase 7 of the start bit, the frame is dropped and no strobe follows. If it is still low, the frame goes on.
- R3: With `voteMode` = 0, each bit takes the value of its phase-7 tick alone.
- R4: With `voteMode` = 1, each bit is the majority of its ticks at phases 6, 7 and 8.
- R5: With `voteMode` = 2, each bit is the majority of its ticks at phases 4 to 11.
- R6: With `voteMode` = 3, each bit is the majority of all sixteen of its ticks.
- R7: When an even window splits evenly, the bit is decided as 1.
- R8: The first data bit lands in `rxData[0]`. `rxValid` is high for exactly one clock, in the cycle after the tick that closes the stop bit.
- R9: When the stop bit is voted 0, `frameErr` is 1 and the byte is still delivered with its strobe. `frameErr` is refreshed with every strobe.
- R10: With `resyncEn` = 1, a line transition inside a data or stop bit restarts the phase count. At phases 1 to 7 the current bit restarts. At phases 8 to 15 the current bit is closed and the next bit begins. This keeps alternating data correct at a 6% baud error in the sixteen-tick window.
- R11: `rxIn` goes through two flip-flops and is looked at only on ticks. A low pulse that is over before the next tick is ignored.
- R12: In modes 1 to 3, frames with up to ±3% baud error and one flipped tick inside the data or stop bits are received correctly. In mode 0, frames with up to ±3% baud error are received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleEn | input | 1 | Sampling tick, sixteen per bit period |
| rxIn | input | 1 | Asynchronous serial line, idle high |
| voteMode | input | 2 | Vote window: 0 centre, 1 three, 2 eight, 3 sixteen |
| resyncEn | input | 1 | Realign the phase count on data transitions |
| rxData | output | DATA_BITS | Received byte |
| rxValid | output | 1 | One-cycle strobe per completed frame |
| frameErr | output | 1 | Stop bit of the last frame was voted 0 |

## Verification
The bench uses the default width of eight data bits and gives a sampling tick every fourth clock. That spacing lets the two-flop synchroniser settle before each tick. It also leaves room for a sub-tick pulse between ticks, which brings the ignored-pulse case within reach. Because the bench drives the line one tick at a time, it can flip exactly the phases that decide a vote, including the even splits. Stretching or shrinking the bit length by a set per-mille figure pushes the windows against neighbouring bits, so the drift and realign cases can be exercised.

// File: rtl/uvr_pkg.sv
package uvr_pkg;

  localparam int PH_W  = 4;
  localparam int CNT_W = PH_W + 1;

  localparam logic [PH_W-1:0] PH_CENTRE = 4'd7;
  localparam logic [PH_W-1:0] PH_LAST   = 4'd15;
  localparam logic [PH_W-1:0] PH_HALF   = 4'd8;

  // strobes from control to datapath, valid in a sampling tick
  typedef struct packed {
    logic take;     // add this tick to the vote
    logic clear;    // drop the counts gathered so far
    logic decide;   // close a bit
    logic early;    // close with the counts held before this tick
    logic stopBit;  // the bit being closed is the stop bit
  } dpStrobe_t;

  function automatic logic inWindow(input logic [1:0] mode, input logic [PH_W-1:0] ph);
    case (mode)
      2'd0:    return ph == PH_CENTRE;
      2'd1:    return (ph >= 4'd6) && (ph <= 4'd8);
      2'd2:    return (ph >= 4'd4) && (ph <= 4'd11);
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/uvr_ctrl.sv
module uvr_ctrl
  import uvr_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleEn,
  input  logic       rxS,
  input  logic       rxEdge,
  input  logic [1:0] voteMode,
  input  logic       resyncEn,
  output dpStrobe_t  strobe
);

  localparam int IDX_W = $clog2(DATA_BITS + 2);
  localparam logic [IDX_W-1:0] STOP_IDX = IDX_W'(DATA_BITS + 1);

  logic            active;
  logic [PH_W-1:0] phase;
  logic [IDX_W-1:0] bitIdx;

  logic inData, edgeHit, earlyHit, lateHit, atStop;
  logic [PH_W-1:0] effPhase;

  always_comb begin
    inData   = active && (bitIdx != '0);
    atStop   = bitIdx == STOP_IDX;
    edgeHit  = resyncEn && inData && rxEdge && (phase != '0);
    earlyHit = edgeHit && (phase >= PH_HALF);
    lateHit  = edgeHit && (phase < PH_HALF);
    effPhase = edgeHit ? '0 : phase;

    strobe.take    = sampleEn && inData && inWindow(voteMode, effPhase)
                     && !(earlyHit && atStop);
    strobe.clear   = sampleEn && edgeHit;
    strobe.decide  = sampleEn && inData && (earlyHit || (phase == PH_LAST));
    strobe.early   = earlyHit;
    strobe.stopBit = atStop;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      phase  <= '0;
      bitIdx <= '0;
    end else if (sampleEn) begin
      if (!active) begin
        if (!rxS) begin
          active <= 1'b1;
          bitIdx <= '0;
          phase  <= 4'd1;
        end
      end else if (bitIdx == '0) begin
        if ((phase == PH_CENTRE) && rxS) begin
          active <= 1'b0;
          phase  <= '0;
        end else begin
          phase <= phase + 4'd1;
          if (phase == PH_LAST) bitIdx <= IDX_W'(1);
        end
      end else if (earlyHit) begin
        if (atStop) begin
          bitIdx <= '0;
          if (!rxS) phase <= 4'd1;
          else begin
            active <= 1'b0;
            phase  <= '0;
          end
        end else begin
          bitIdx <= bitIdx + IDX_W'(1);
          phase  <= 4'd1;
        end
      end else if (lateHit) begin
        phase <= 4'd1;
      end else if (phase == PH_LAST) begin
        phase <= '0;
        if (atStop) active <= 1'b0;
        else        bitIdx <= bitIdx + IDX_W'(1);
      end else begin
        phase <= phase + 4'd1;
      end
    end
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (bitIdx <= STOP_IDX)); // R8

  AST_START_GLITCH_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (sampleEn && active && (bitIdx == '0) && (phase == PH_CENTRE) && rxS) |=> !active); // R2

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rstN)
    !sampleEn |=> ($stable(phase) && $stable(bitIdx) && $stable(active))); // R11

endmodule

// File: rtl/uvr_datapath.sv
module uvr_datapath
  import uvr_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleEn,
  input  logic                 rxIn,
  input  dpStrobe_t            strobe,
  output logic                 rxS,
  output logic                 rxEdge,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxValid,
  output logic                 frameErr
);

  logic syncA, syncB, rxPrev;
  logic [CNT_W-1:0] ones, win;
  logic [CNT_W-1:0] baseOnes, baseWin, addOnes, addWin, decOnes, decWin;
  logic vote;
  logic [DATA_BITS-1:0] shiftReg;

  assign rxS    = syncB;
  assign rxEdge = syncB ^ rxPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b1;
      syncB <= 1'b1;
    end else begin
      syncA <= rxIn;
      syncB <= syncA;
    end
  end

  always_comb begin
    baseOnes = strobe.clear ? '0 : ones;
    baseWin  = strobe.clear ? '0 : win;
    addOnes  = baseOnes + CNT_W'(strobe.take & syncB);
    addWin   = baseWin + CNT_W'(strobe.take);
    decOnes  = strobe.early ? ones : addOnes;
    decWin   = strobe.early ? win  : addWin;
    vote     = {decOnes, 1'b0} >= {1'b0, decWin};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxPrev   <= 1'b1;
      ones     <= '0;
      win      <= '0;
      shiftReg <= '0;
      rxData   <= '0;
      rxValid  <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (sampleEn) begin
        rxPrev <= syncB;
        if (strobe.decide && !strobe.early) begin
          ones <= '0;
          win  <= '0;
        end else begin
          ones <= addOnes;
          win  <= addWin;
        end
        if (strobe.decide) begin
          if (strobe.stopBit) begin
            rxData   <= shiftReg;
            frameErr <= ~vote;
            rxValid  <= 1'b1;
          end else begin
            shiftReg <= {vote, shiftReg[DATA_BITS-1:1]};
          end
        end
      end
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid); // R8

  AST_VALID_FROM_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxValid) |-> $past(sampleEn)); // R8

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (ones <= win) && (win <= CNT_W'(16))); // R6

endmodule

// File: rtl/uart_vote_rx.sv
module uart_vote_rx
  import uvr_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleEn,
  input  logic                 rxIn,
  input  logic [1:0]           voteMode,
  input  logic                 resyncEn,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxValid,
  output logic                 frameErr
);

  dpStrobe_t strobe;
  logic rxS, rxEdge;

  uvr_ctrl #(.DATA_BITS(DATA_BITS)) uCtrl (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .rxS(rxS), .rxEdge(rxEdge),
    .voteMode(voteMode), .resyncEn(resyncEn), .strobe(strobe)
  );

  uvr_datapath #(.DATA_BITS(DATA_BITS)) uPath (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .rxIn(rxIn), .strobe(strobe),
    .rxS(rxS), .rxEdge(rxEdge), .rxData(rxData), .rxValid(rxValid), .frameErr(frameErr)
  );

endmodule

// File: tb/sim_uart_vote_rx.sv
`timescale 1ns/1ps
module sim_uart_vote_rx;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleEn = 1'b0;
  logic rxIn = 1'b1;
  logic [1:0] voteMode = 2'd0;
  logic resyncEn = 1'b0;
  logic [7:0] rxData;
  logic rxValid, frameErr;

  always #2.5 clk = ~clk;

  uart_vote_rx #(.DATA_BITS(8)) u0 (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .rxIn(rxIn), .voteMode(voteMode),
    .resyncEn(resyncEn), .rxData(rxData), .rxValid(rxValid), .frameErr(frameErr)
  );

  int checks = 0;
  int errors = 0;
  int gotCnt = 0;
  logic [7:0] gotData;
  logic gotErr;
  logic prevValid = 1'b0;
  logic wideErr = 1'b0;
  logic finished = 1'b0;

  localparam int LEAD = 4;
  logic lineBuf [0:299];
  int lineLen;

  always @(negedge clk) begin
    if (rstN) begin
      if (rxValid) begin
        gotCnt++;
        gotData = rxData;
        gotErr = frameErr;
        if (prevValid) wideErr = 1'b1;
      end
      prevValid = rxValid;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic frameBit(input logic [7:0] d, input logic stopV, input int s, input int scale);
    int b;
    b = (s * 1000) / (16 * scale);
    if (b == 0) return 1'b0;
    if (b <= 8) return d[b-1];
    return stopV;
  endfunction

  task automatic buildFrame(input logic [7:0] d, input logic stopV, input int scale);
    int n;
    n = (160 * scale + 999) / 1000;
    lineLen = 0;
    for (int i = 0; i < LEAD; i++) begin lineBuf[lineLen] = 1'b1; lineLen++; end
    for (int s = 0; s < n; s++) begin lineBuf[lineLen] = frameBit(d, stopV, s, scale); lineLen++; end
    for (int i = 0; i < 40; i++) begin lineBuf[lineLen] = 1'b1; lineLen++; end
  endtask

  // flip phases lo..hi of bit k (nominal timing)
  task automatic flipRange(input int k, input int lo, input int hi);
    for (int p = lo; p <= hi; p++) lineBuf[LEAD + 16*k + p] = ~lineBuf[LEAD + 16*k + p];
  endtask

  task automatic tick();
    repeat (3) @(posedge clk);
    #1 sampleEn = 1'b1;
    @(posedge clk);
    #1 sampleEn = 1'b0;
  endtask

  task automatic play();
    gotCnt = 0;
    wideErr = 1'b0;
    for (int i = 0; i < lineLen; i++) begin
      rxIn = lineBuf[i];
      tick();
    end
    repeat (4) @(posedge clk);
  endtask

  task automatic expectFrame(input string req, input logic [7:0] expD, input logic expErr);
    check(gotCnt == 1, req, "strobe count", gotCnt, 1);
    check(gotData == expD, req, "data", gotData, expD);
    check(gotErr == expErr, req, "frameErr", gotErr, expErr);
    check(!wideErr, req, "strobe width", wideErr, 0);
  endtask

  task automatic directed(input string req, input logic [1:0] mode, input logic [7:0] d,
                          input int k, input int lo, input int hi, input logic [7:0] expD);
    voteMode = mode;
    resyncEn = 1'b0;
    buildFrame(d, 1'b1, 1000);
    if (lo >= 0) flipRange(k, lo, hi);
    play();
    expectFrame(req, expD, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED);
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    // R1 reset state
    check(rxValid == 1'b0, "R1", "rxValid", rxValid, 0);
    check(rxData == 8'h00, "R1", "rxData", rxData, 0);
    check(frameErr == 1'b0, "R1", "frameErr", frameErr, 0);

    // R3 centre tick only
    directed("R3", 2'd0, 8'h00, 1, 7, 7, 8'h01);
    directed("R3", 2'd0, 8'h00, 1, 6, 6, 8'h00);
    directed("R3", 2'd0, 8'h00, 1, 8, 8, 8'h00);
    // R4 three ticks
    directed("R4", 2'd1, 8'h00, 1, 7, 7, 8'h00);
    voteMode = 2'd1;
    buildFrame(8'h00, 1'b1, 1000);
    flipRange(1, 6, 6); flipRange(1, 8, 8);
    play(); expectFrame("R4", 8'h01, 1'b0);
    // R5 eight middle ticks
    voteMode = 2'd2;
    buildFrame(8'h00, 1'b1, 1000);
    flipRange(1, 0, 3); flipRange(1, 12, 15);
    play(); expectFrame("R5", 8'h00, 1'b0);
    buildFrame(8'h00, 1'b1, 1000);
    flipRange(1, 4, 5); flipRange(1, 11, 11);
    play(); expectFrame("R5", 8'h00, 1'b0);
    // R7 even split in eight-tick window
    directed("R7", 2'd2, 8'h00, 1, 8, 11, 8'h01);
    // R6 sixteen ticks, R7 even split
    directed("R6", 2'd3, 8'h00, 2, 0, 6, 8'h00);
    directed("R7", 2'd3, 8'h00, 2, 0, 7, 8'h02);
    directed("R7", 2'd3, 8'hFF, 1, 8, 15, 8'hFF);
    directed("R6", 2'd3, 8'hFF, 1, 7, 15, 8'hFE);
    // R8 bit order
    directed("R8", 2'd1, 8'h01, 0, -1, -1, 8'h01);
    directed("R8", 2'd1, 8'h80, 0, -1, -1, 8'h80);

    // R2 short low run is dropped, long one starts a frame
    voteMode = 2'd1;
    lineLen = 0;
    for (int i = 0; i < 4; i++) begin lineBuf[lineLen] = 1'b1; lineLen++; end
    for (int i = 0; i < 7; i++) begin lineBuf[lineLen] = 1'b0; lineLen++; end
    for (int i = 0; i < 200; i++) begin lineBuf[lineLen] = 1'b1; lineLen++; end
    play();
    check(gotCnt == 0, "R2", "strobe after 7-tick low", gotCnt, 0);
    lineLen = 0;
    for (int i = 0; i < 4; i++) begin lineBuf[lineLen] = 1'b1; lineLen++; end
    for (int i = 0; i < 8; i++) begin lineBuf[lineLen] = 1'b0; lineLen++; end
    for (int i = 0; i < 200; i++) begin lineBuf[lineLen] = 1'b1; lineLen++; end
    play();
    expectFrame("R2", 8'hFF, 1'b0);

    // R9 framing error then a clean frame clears it
    voteMode = 2'd3;
    buildFrame(8'hA5, 1'b0, 1000);
    play(); expectFrame("R9", 8'hA5, 1'b1);
    buildFrame(8'h3C, 1'b1, 1000);
    play(); expectFrame("R9", 8'h3C, 1'b0);

    // R11 sub-tick pulse on idle line
    gotCnt = 0;
    rxIn = 1'b1;
    tick();
    rxIn = 1'b0;
    @(posedge clk);
    #1 rxIn = 1'b1;
    for (int i = 0; i < 200; i++) tick();
    check(gotCnt == 0, "R11", "strobe after sub-tick pulse", gotCnt, 0);

    // R10 realign at 6% error with alternating data
    voteMode = 2'd3;
    resyncEn = 1'b1;
    buildFrame(8'h55, 1'b1, 1065);
    play(); expectFrame("R10", 8'h55, 1'b0);
    buildFrame(8'hAA, 1'b1, 940);
    play(); expectFrame("R10", 8'hAA, 1'b0);

    // R12 random frames: drift, single glitch, realign
    for (int f = 0; f < 32; f++) begin
      logic [7:0] d;
      int scale, n, g;
      d = 8'($urandom);
      scale = 970 + int'($urandom % 61);
      voteMode = 2'($urandom);
      resyncEn = ($urandom % 2) == 1;
      buildFrame(d, 1'b1, scale);
      if (!resyncEn && voteMode != 2'd0) begin
        n = (160 * scale + 999) / 1000;
        g = LEAD + 20 + int'($urandom % (n - 40));
        lineBuf[g] = ~lineBuf[g];
      end
      play();
      expectFrame("R12", d, 1'b0);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule